// File: doc/BRIEF.md
# Four-Register Configurable Pipeline File

The block holds four equal-width registers, numbered one to four. They can run as one four-deep delay line or as two separate two-deep pipelines. A 2-bit instruction, sampled at each rising clock edge, decides which registers take the data input, which take their upstream neighbour's value and which keep their contents. A 2-bit read select feeds a combinational 4-to-1 multiplexer that places any one register on the output. Reads and writes are controlled separately, so one register can be read in the same cycle that another is written.

The pipeline halves are stages 1–2 and stages 3–4. A compile-time parameter, `VARIANT_HOLD`, sets what the second stage of a pair does when the first stage of that pair is loaded from the input. With 0 it takes the old first-stage value (shifting variant). With 1 it keeps its own value (holding variant). The active-low output enable gives a valid flag. While the output is disabled the data output reads zero.

Top module: `pipe_regfile4`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero at the rising edge where it is sampled high.
- R2: Instruction 2'b00 shifts the whole chain at the edge, using the values held before the edge: the input goes to register 1, register 1 to register 2, register 2 to register 3 and register 3 to register 4.
- R3: Instruction 2'b01 loads the input into register 3 and leaves registers 1 and 2 unchanged. In the shifting variant (`VARIANT_HOLD`=0), register 4 takes the old register 3 value.
- R4: Instruction 2'b10 loads the input into register 1 and leaves registers 3 and 4 unchanged. In the shifting variant, register 2 takes the old register 1 value.
- R5: Instruction 2'b11 leaves all four registers unchanged.
- R6: The read select routes registers to the output as follows: 2'b00 selects register 4, 2'b01 selects register 3, 2'b10 selects register 2 and 2'b11 selects register 1. The output follows a change of select within the same cycle, without waiting for a clock edge.
- R7: In the holding variant (`VARIANT_HOLD`=1), register 4 keeps its value under instruction 2'b01, and register 2 keeps its value under instruction 2'b10.
- R8: While `oe_n` is high, `y_valid` is 0 and `y` is all zeros. While `oe_n` is low, `y_valid` is 1. The register transfers go on unchanged whatever the state of `oe_n`.
- R9: If a register is selected for reading while it is being written, the output shows its old value until the edge and the new value after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 2 | Transfer instruction: load, shift or hold |
| d | input | WIDTH | Data input |
| sel | input | 2 | Read select for the output multiplexer |
| oe_n | input | 1 | Active-low output enable |
| y | output | WIDTH | Selected register, or zero while disabled |
| y_valid | output | 1 | High while the output is enabled |

## Verification
The bench builds two copies of the block side by side, both at the default width of 16: one with `VARIANT_HOLD`=0 and one with `VARIANT_HOLD`=1. Both copies receive the same stimulus. This brings within reach every point where the two variants differ, namely the second stage of each pair under the split-load instructions, while every other transfer must agree between the copies. Sweeping the read select after each step makes all four registers visible through the multiplexer alone.

// File: rtl/pipe_regfile_pkg.sv
package pipe_regfile_pkg;

    localparam int NREG = 4;

    localparam int IDX_R1 = 0;
    localparam int IDX_R2 = 1;
    localparam int IDX_R3 = 2;
    localparam int IDX_R4 = 3;

    typedef enum logic [1:0] {
        INS_SHIFT_ALL = 2'b00,
        INS_LOAD_HI   = 2'b01,
        INS_LOAD_LO   = 2'b10,
        INS_HOLD      = 2'b11
    } instr_e;

endpackage

// File: rtl/prf_instr_decode.sv
module prf_instr_decode
    import pipe_regfile_pkg::*;
#(
    parameter bit VARIANT_HOLD = 1'b0
) (
    input  logic [1:0]      instr,
    output logic [NREG-1:0] ld_input,
    output logic [NREG-1:0] ld_chain
);

    instr_e op;

    always_comb begin
        op       = instr_e'(instr);
        ld_input = '0;
        ld_chain = '0;
        unique case (op)
            INS_SHIFT_ALL: begin
                ld_input[IDX_R1] = 1'b1;
                ld_chain[IDX_R2] = 1'b1;
                ld_chain[IDX_R3] = 1'b1;
                ld_chain[IDX_R4] = 1'b1;
            end
            INS_LOAD_HI: begin
                ld_input[IDX_R3] = 1'b1;
                ld_chain[IDX_R4] = !VARIANT_HOLD;
            end
            INS_LOAD_LO: begin
                ld_input[IDX_R1] = 1'b1;
                ld_chain[IDX_R2] = !VARIANT_HOLD;
            end
            INS_HOLD: begin
                ld_input = '0;
                ld_chain = '0;
            end
            default: begin
                ld_input = '0;
                ld_chain = '0;
            end
        endcase
    end

endmodule

// File: rtl/prf_stage_bank.sv
module prf_stage_bank
    import pipe_regfile_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [WIDTH-1:0]           d,
    input  logic [NREG-1:0]            ld_input,
    input  logic [NREG-1:0]            ld_chain,
    output logic [NREG-1:0][WIDTH-1:0] regs_q
);

    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] stage;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;
    logic [NREG-1:0][WIDTH-1:0] chain_src;

    assign chain_src[0] = d;

    for (genvar gi = 1; gi < NREG; gi++) begin : g_chain
        assign chain_src[gi] = bank_q.stage[gi-1];
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NREG; i++) begin
            if (ld_input[i]) begin
                bank_d.stage[i] = d;
            end else if (ld_chain[i]) begin
                bank_d.stage[i] = chain_src[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_q = bank_q.stage;

endmodule

// File: rtl/prf_read_mux.sv
module prf_read_mux
    import pipe_regfile_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SEL_W = 2
) (
    input  logic [NREG-1:0][WIDTH-1:0] regs,
    input  logic [SEL_W-1:0]           sel,
    input  logic                       oe_n,
    output logic [WIDTH-1:0]           y,
    output logic                       y_valid
);

    logic [SEL_W-1:0] idx;

    always_comb begin
        idx     = SEL_W'(NREG - 1) - sel;
        y_valid = !oe_n;
        y       = oe_n ? '0 : regs[idx];
    end

endmodule

// File: rtl/pipe_regfile4.sv
module pipe_regfile4
    import pipe_regfile_pkg::*;
#(
    parameter int WIDTH        = 16,
    parameter bit VARIANT_HOLD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       instr,
    input  logic [WIDTH-1:0] d,
    input  logic [1:0]       sel,
    input  logic             oe_n,
    output logic [WIDTH-1:0] y,
    output logic             y_valid
);

    localparam int SEL_W = $clog2(NREG);

    logic [NREG-1:0]            ld_input;
    logic [NREG-1:0]            ld_chain;
    logic [NREG-1:0][WIDTH-1:0] regs_q;

    prf_instr_decode #(
        .VARIANT_HOLD(VARIANT_HOLD)
    ) decode_i (
        .instr   (instr),
        .ld_input(ld_input),
        .ld_chain(ld_chain)
    );

    prf_stage_bank #(
        .WIDTH(WIDTH)
    ) bank_i (
        .clk     (clk),
        .rst     (rst),
        .d       (d),
        .ld_input(ld_input),
        .ld_chain(ld_chain),
        .regs_q  (regs_q)
    );

    prf_read_mux #(
        .WIDTH(WIDTH),
        .SEL_W(SEL_W)
    ) mux_i (
        .regs   (regs_q),
        .sel    (sel[SEL_W-1:0]),
        .oe_n   (oe_n),
        .y      (y),
        .y_valid(y_valid)
    );

endmodule

// File: rtl/pipe_regfile4_chk.sv
module pipe_regfile4_chk
    import pipe_regfile_pkg::*;
#(
    parameter int WIDTH        = 16,
    parameter bit VARIANT_HOLD = 1'b0
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 instr,
    input logic [WIDTH-1:0]           d,
    input logic [1:0]                 sel,
    input logic                       oe_n,
    input logic [WIDTH-1:0]           y,
    input logic                       y_valid,
    input logic [NREG-1:0][WIDTH-1:0] regs_q
);

    logic [1:0] rd_idx;
    assign rd_idx = 2'(NREG - 1) - sel;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    a_r2_chain_shift: assert property (@(posedge clk) disable iff (rst)
        (instr == 2'b00) |=> (regs_q[IDX_R1] == $past(d))
                          && (regs_q[IDX_R2] == $past(regs_q[IDX_R1]))
                          && (regs_q[IDX_R3] == $past(regs_q[IDX_R2]))
                          && (regs_q[IDX_R4] == $past(regs_q[IDX_R3])));

    a_r3_load_hi: assert property (@(posedge clk) disable iff (rst)
        (instr == 2'b01) |=> (regs_q[IDX_R3] == $past(d))
                          && $stable(regs_q[IDX_R1]) && $stable(regs_q[IDX_R2]));

    a_r4_load_lo: assert property (@(posedge clk) disable iff (rst)
        (instr == 2'b10) |=> (regs_q[IDX_R1] == $past(d))
                          && $stable(regs_q[IDX_R3]) && $stable(regs_q[IDX_R4]));

    a_r5_hold_all: assert property (@(posedge clk) disable iff (rst)
        (instr == 2'b11) |=> $stable(regs_q));

    a_r7_pair_tail_hi: assert property (@(posedge clk) disable iff (rst)
        (instr == 2'b01) |=> (regs_q[IDX_R4] ==
            (VARIANT_HOLD ? $past(regs_q[IDX_R4]) : $past(regs_q[IDX_R3]))));

    a_r7_pair_tail_lo: assert property (@(posedge clk) disable iff (rst)
        (instr == 2'b10) |=> (regs_q[IDX_R2] ==
            (VARIANT_HOLD ? $past(regs_q[IDX_R2]) : $past(regs_q[IDX_R1]))));

    a_r6_read_route: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (y_valid && (y == regs_q[rd_idx])));

    a_r8_disabled_out: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!y_valid && (y == '0)));

endmodule

bind pipe_regfile4 pipe_regfile4_chk #(
    .WIDTH       (WIDTH),
    .VARIANT_HOLD(VARIANT_HOLD)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .instr  (instr),
    .d      (d),
    .sel    (sel),
    .oe_n   (oe_n),
    .y      (y),
    .y_valid(y_valid),
    .regs_q (regs_q)
);

// File: tb/pipe_regfile4_tb_top.sv
module pipe_regfile4_tb_top;

    localparam int W    = 16;
    localparam int NVEC = 12;

    // each entry: {instr[1:0], d[15:0]}
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {2'b00, 16'h1111}, {2'b00, 16'h2222}, {2'b00, 16'h3333},
        {2'b00, 16'h4444}, {2'b01, 16'hA5A5}, {2'b10, 16'h5A5A},
        {2'b11, 16'hFFFF}, {2'b01, 16'h0F0F}, {2'b01, 16'hBEEF},
        {2'b10, 16'hCAFE}, {2'b10, 16'h1234}, {2'b00, 16'h8001}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   instr = 2'b11;
    logic [W-1:0] d = '0;
    logic [1:0]   sel = 2'b00;
    logic         oe_n = 1'b0;
    logic [W-1:0] y0, y1;
    logic         v0, v1;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    // model[variant][register index 0..3 = R1..R4]
    logic [W-1:0] model [0:1][0:3];

    always #2.5 clk = ~clk;

    pipe_regfile4 #(.WIDTH(W), .VARIANT_HOLD(1'b0)) dut_i (
        .clk(clk), .rst(rst), .instr(instr), .d(d), .sel(sel),
        .oe_n(oe_n), .y(y0), .y_valid(v0)
    );

    pipe_regfile4 #(.WIDTH(W), .VARIANT_HOLD(1'b1)) dut_hold_i (
        .clk(clk), .rst(rst), .instr(instr), .d(d), .sel(sel),
        .oe_n(oe_n), .y(y1), .y_valid(v1)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int v = 0; v < 2; v++)
            for (int r = 0; r < 4; r++) model[v][r] = '0;
    endtask

    task automatic model_step(input logic [1:0] op, input logic [W-1:0] din);
        for (int v = 0; v < 2; v++) begin
            case (op)
                2'b00: begin
                    model[v][3] = model[v][2];
                    model[v][2] = model[v][1];
                    model[v][1] = model[v][0];
                    model[v][0] = din;
                end
                2'b01: begin
                    if (v == 0) model[v][3] = model[v][2];
                    model[v][2] = din;
                end
                2'b10: begin
                    if (v == 0) model[v][1] = model[v][0];
                    model[v][0] = din;
                end
                default: ;
            endcase
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [W-1:0] din);
        @(negedge clk);
        instr = op;
        d     = din;
        @(posedge clk);
        model_step(op, din);
        #1;
        instr = 2'b11;
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            sel = 2'(s);
            #1;
            chk(req, y0, model[0][3-s]);
            chk(req, y1, model[1][3-s]);
        end
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1 after reset");

        for (int k = 0; k < NVEC; k++) begin
            apply(VEC[k][17:16], VEC[k][15:0]);
            case (VEC[k][17:16])
                2'b00: sweep("R2 shift chain");
                2'b01: sweep("R3/R7 load R3");
                2'b10: sweep("R4/R7 load R1");
                default: sweep("R5 hold");
            endcase
        end

        // R6: select changes within one low phase, no edge between
        @(negedge clk);
        sel = 2'b11; #0.5;
        chk("R6 sel 11 -> R1", y0, model[0][0]);
        sel = 2'b00; #0.5;
        chk("R6 sel 00 -> R4", y0, model[0][3]);

        // R8: output disabled, transfers still happen
        @(negedge clk);
        oe_n = 1'b1;
        sel  = 2'b11;
        #1;
        chk("R8 y zero while disabled", y0, '0);
        chk("R8 valid low while disabled", {15'd0, v0}, 16'd0);
        chk("R8 hold-variant valid low", {15'd0, v1}, 16'd0);
        apply(2'b00, 16'h7E57);
        #1;
        chk("R8 y still zero", y1, '0);
        @(negedge clk);
        oe_n = 1'b0;
        #1;
        chk("R8 valid high when enabled", {15'd0, v0}, 16'd1);
        sweep("R8 shift under disable");

        // R9: read R1 while it is being written
        @(negedge clk);
        sel   = 2'b11;
        instr = 2'b10;
        d     = 16'hD00D;
        #1;
        chk("R9 old value before edge", y0, model[0][0]);
        @(posedge clk);
        model_step(2'b10, 16'hD00D);
        #1;
        instr = 2'b11;
        chk("R9 new value after edge", y0, 16'hD00D);
        chk("R9 new value hold variant", y1, 16'hD00D);
        sweep("R7 after R9 load");

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        sweep("R1 mid-run reset");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule